// File: doc/BRIEF.md
# D-Channel Serial Data Port

This block carries the 16 kb/s signalling channel of a basic-access 2B+D link between a parallel core and a serial line. Each frame holds two D bits. The core hands the port one 2-bit word to send and gets back one 2-bit word it received. Bit 1 of a word always travels first on the wire.

The port has two framing modes, chosen by `mode_sel`.

- **Slot mode (`mode_sel` = 0).** The port follows an external bit clock and frame sync. It moves its two bits only at a programmable bit offset inside each frame. With `fmt4_sel` set, it advances one bit for every two bit-clock periods.
- **Free-running mode (`mode_sel` = 1).** The port divides the system clock to make its own D clock. It moves a bit on every period of that clock.

All inputs are synchronous to `clk`. The bit clock and frame sync are sampled and their edges are detected inside the port.

The transmit side is a valid/ready stream with the following back-pressure rules.
- `tx_ready` pulses for one cycle when the port is about to put out the first bit of a frame.
- A word is taken only when `tx_valid` is high in that cycle.
- If `tx_valid` is low, the frame carries idle ones. There is no retry.
- The receive side cannot be stalled by the line, so `rx_valid` is a one-cycle strobe. A word that is not taken in that cycle is lost.

Top module: `dport_top`

## Requirements
- R1: While `port_en` is low, `d_out` is 1, `dclk_out` is 0, and `rx_valid` and `tx_ready` never assert, whatever the bit clock and frame sync do.
- R2: In free-running mode, `dclk_out` starts low and toggles every HALF_PER `clk` cycles.
- R3: In free-running mode, `d_out` changes only together with a rising edge of `dclk_out`. The first rising edge of each pair carries word bit 1 and the second carries bit 0.
- R4: In free-running mode, `d_in` is sampled at falling edges of `dclk_out`. The first sample becomes `rx_data[1]` and the second becomes `rx_data[0]`.
- R5: In slot mode, position 0 is the bit-clock rising edge at which `fsync` is first seen high. Each counted rising edge adds one. Positions `slot_pos` and `slot_pos`+1 carry word bits 1 and 0. At every other counted position `d_out` is 1, as it is before the first frame sync.
- R6: In slot mode, `d_out` changes only in the cycle after a bit-clock rising edge is sampled. `d_in` is sampled at the bit-clock falling edge that follows an in-slot position.
- R7: With `fmt4_sel` high in slot mode, only every second rising edge is counted, starting with the frame-start edge. The falling edge right after a counted rise is the sampling edge.
- R8: `tx_ready` is a one-cycle pulse, given once per frame at the first slot bit. With `tx_valid` low at that pulse, both bits of the frame are 1.
- R9: `rx_valid` pulses for exactly one cycle per frame, once the second bit is sampled.
- R10: In slot mode `dclk_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | Port enable |
| mode_sel | input | 1 | 0 = slot mode, 1 = free-running mode |
| fmt4_sel | input | 1 | Half-rate bit timing in slot mode |
| slot_pos | input | POS_W | Bit offset of the D slot within a frame |
| bclk | input | 1 | External bit clock (level, sampled) |
| fsync | input | 1 | Frame sync (level, sampled at bit-clock rises) |
| d_in | input | 1 | Serial D data from the line side |
| d_out | output | 1 | Serial D data to the line side, idle high |
| dclk_out | output | 1 | Generated D clock (free-running mode) |
| tx_data | input | 2 | Word to send, bit 1 first |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit word taken this cycle if valid |
| rx_data | output | 2 | Received word, bit 1 first received |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The bench places the slot at position 0, in the middle of the frame, and on the last two positions of a frame. An off-by-one in the position count would show up as shifted or missing bits, or as a word that is never delivered. Half-rate timing is checked by holding the line value across both bit-clock periods of each bit. A port that counted every rise would run the slot at double speed and sample the wrong period. In free-running mode the bench checks the following:
- the D clock half-period;
- that data moves only with clock rises;
- the bit order in both directions.

Disabled and starved-transmit frames confirm that idle ones go out and that the handshake strobes stay quiet.

// File: rtl/dport_pkg.sv
package dport_pkg;
  typedef enum logic {
    DP_SLOT = 1'b0,
    DP_FREE = 1'b1
  } dport_mode_e;

  // Bit-level timing events shared by the two framing generators.
  typedef struct packed {
    logic drive;   // put a slot bit on the output
    logic idle;    // counted position outside the slot
    logic samp;    // capture a slot bit from the input
    logic idx;     // 0 = first bit of word, 1 = second
  } dport_stb_t;
endpackage

// File: rtl/dport_free_clkgen.sv
module dport_free_clkgen #(
  parameter int HALF_PER = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk,
  output dport_pkg::dport_stb_t stb
);
  localparam int CW = $clog2(HALF_PER + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

  logic [CW-1:0] cnt;
  logic          idx;
  logic          wrap;

  assign wrap = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dclk <= 1'b0;
      idx  <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      dclk <= 1'b0;
      idx  <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      dclk <= ~dclk;
      if (dclk) idx <= ~idx;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_comb begin
    stb.drive = wrap && !dclk;
    stb.samp  = wrap && dclk;
    stb.idle  = 1'b0;
    stb.idx   = idx;
  end

  AST_FREE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $fell(dclk)) |-> (idx != $past(idx))); // R4
endmodule

// File: rtl/dport_slot_timer.sv
module dport_slot_timer #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fmt4,
  input  logic [POS_W-1:0] slot_pos,
  input  logic             bclk,
  input  logic             fsync,
  output dport_pkg::dport_stb_t stb
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             bclk_q, fs_last, synced, ph, armed;
  logic [POS_W-1:0] pos, pos_nxt;
  logic             rise, fall, fs_start, eff, synced_nxt;

  function automatic logic in_slot(input logic [POS_W-1:0] p, input logic ok);
    logic [POS_W:0] first;
    first = {1'b0, slot_pos};
    return ok && (({1'b0, p} == first) || ({1'b0, p} == first + (POS_W+1)'(1)));
  endfunction

  assign rise       = run && bclk && !bclk_q;
  assign fall       = run && !bclk && bclk_q;
  assign fs_start   = rise && fsync && !fs_last;
  assign eff        = rise && (fs_start || !fmt4 || !ph);
  assign pos_nxt    = fs_start ? '0 : ((pos == POS_MAX) ? pos : pos + POS_W'(1));
  assign synced_nxt = synced || fs_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_last <= 1'b0;
      synced  <= 1'b0;
      ph      <= 1'b0;
      armed   <= 1'b0;
      pos     <= POS_MAX;
    end else begin
      bclk_q <= bclk;
      if (!run) begin
        fs_last <= 1'b0;
        synced  <= 1'b0;
        ph      <= 1'b0;
        armed   <= 1'b0;
        pos     <= POS_MAX;
      end else if (rise) begin
        fs_last <= fsync;
        if (eff) begin
          pos    <= pos_nxt;
          synced <= synced_nxt;
          ph     <= fmt4;
          armed  <= 1'b1;
        end else begin
          ph    <= 1'b0;
          armed <= 1'b0;
        end
      end else if (fall) begin
        armed <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.drive = eff && in_slot(pos_nxt, synced_nxt);
    stb.idle  = eff && !in_slot(pos_nxt, synced_nxt);
    stb.samp  = fall && armed && in_slot(pos, synced);
    stb.idx   = fall ? (pos != slot_pos) : (pos_nxt != slot_pos);
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.drive && stb.samp)); // R6
  AST_HALF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fmt4 && $past(run && fmt4) && eff && !fs_start) |-> !armed); // R7
endmodule

// File: rtl/dport_shifter.sv
module dport_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  dport_pkg::dport_stb_t stb,
  input  logic       d_in,
  input  logic [1:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       d_out,
  output logic [1:0] rx_data,
  output logic       rx_valid
);
  logic [1:0] hold;
  logic       rx_first;

  assign tx_ready = run && stb.drive && !stb.idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out    <= 1'b1;
      hold     <= 2'b11;
      rx_first <= 1'b0;
      rx_data  <= 2'b00;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!run) begin
        d_out <= 1'b1;
        hold  <= 2'b11;
      end else begin
        if (stb.drive) begin
          if (!stb.idx) begin
            hold  <= tx_valid ? tx_data : 2'b11;
            d_out <= tx_valid ? tx_data[1] : 1'b1;
          end else begin
            d_out <= hold[0];
          end
        end else if (stb.idle) begin
          d_out <= 1'b1;
        end
        if (stb.samp) begin
          if (!stb.idx) rx_first <= d_in;
          else begin
            rx_data  <= {rx_first, d_in};
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready); // R8
endmodule

// File: rtl/dport_top.sv
module dport_top #(
  parameter int HALF_PER = 3125,
  parameter int POS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             mode_sel,
  input  logic             fmt4_sel,
  input  logic [POS_W-1:0] slot_pos,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             d_in,
  output logic             d_out,
  output logic             dclk_out,
  input  logic [1:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [1:0]       rx_data,
  output logic             rx_valid
);
  import dport_pkg::*;

  dport_mode_e mode;
  logic        run_slot, run_free, dclk_raw;
  dport_stb_t  stb_slot, stb_free, stb;

  assign mode     = dport_mode_e'(mode_sel);
  assign run_slot = port_en && (mode == DP_SLOT);
  assign run_free = port_en && (mode == DP_FREE);

  dport_slot_timer #(.POS_W(POS_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .run(run_slot), .fmt4(fmt4_sel),
    .slot_pos(slot_pos), .bclk(bclk), .fsync(fsync), .stb(stb_slot)
  );

  dport_free_clkgen #(.HALF_PER(HALF_PER)) u_free (
    .clk(clk), .rst_n(rst_n), .run(run_free), .dclk(dclk_raw), .stb(stb_free)
  );

  assign stb      = (mode == DP_FREE) ? stb_free : stb_slot;
  assign dclk_out = run_free && dclk_raw;

  dport_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .run(port_en), .stb(stb), .d_in(d_in),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .d_out(d_out), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (d_out && !rx_valid)); // R1
  AST_FREE_MOVE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && mode_sel && $past(port_en && mode_sel) && !$stable(d_out))
      |-> $rose(dclk_out)); // R3
  AST_SLOT_MOVE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !mode_sel && $past(port_en && !mode_sel) && !$stable(d_out))
      |-> ($past(bclk) && !$past(bclk, 2))); // R6
endmodule

// File: tb/dport_top_tb_top.sv
module dport_top_tb_top;
  localparam int HP = 4;
  localparam int PW = 6;
  localparam int NB = 16;

  logic clk = 0, rst_n = 0;
  logic port_en = 0, mode_sel = 0, fmt4_sel = 0;
  logic [PW-1:0] slot_pos = '0;
  logic bclk = 0, fsync = 0, d_in = 0;
  logic [1:0] tx_data = 2'b00;
  logic tx_valid = 0;
  logic d_out, dclk_out, tx_ready, rx_valid;
  logic [1:0] rx_data;

  int tests = 0, fails = 0;
  logic clr = 0;
  int rdy_cnt, hs_cnt, rx_cnt;
  logic [1:0] rx_hist [4];
  logic done = 0;

  always #5 clk = ~clk;

  dport_top #(.HALF_PER(HP), .POS_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .mode_sel(mode_sel),
    .fmt4_sel(fmt4_sel), .slot_pos(slot_pos), .bclk(bclk), .fsync(fsync),
    .d_in(d_in), .d_out(d_out), .dclk_out(dclk_out), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(posedge clk) begin
    if (clr) begin
      rdy_cnt <= 0; hs_cnt <= 0; rx_cnt <= 0;
    end else begin
      if (tx_ready) rdy_cnt <= rdy_cnt + 1;
      if (tx_ready && tx_valid) hs_cnt <= hs_cnt + 1;
      if (rx_valid) begin
        if (rx_cnt < 4) rx_hist[rx_cnt] <= rx_data;
        rx_cnt <= rx_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic bclk_period(input logic fs, input logic din,
                             output logic dout_s, output logic dclk_s);
    @(negedge clk) begin bclk = 1; fsync = fs; d_in = din; end
    repeat (2) @(negedge clk);
    dout_s = d_out; dclk_s = dclk_out;
    @(negedge clk) bclk = 0;
    repeat (3) @(negedge clk);
    fsync = 0;
  endtask

  // R5 R6 R7 R8 R9 R10: one slot-mode frame with checks on every bit
  task automatic slot_frame(input int slot, input logic f4, input logic [1:0] tx,
                            input logic txv, input logic [1:0] rxw, input string tag);
    int bad = 0, dclk_hi = 0;
    logic [1:0] txe;
    logic ds, cs;
    txe = txv ? tx : 2'b11;
    port_en = 1; mode_sel = 0; fmt4_sel = f4; slot_pos = PW'(slot);
    tx_data = tx; tx_valid = txv;
    clear_counts();
    for (int k = 0; k < NB; k++) begin
      int p;
      logic din, exp;
      p = f4 ? (k >> 1) : k;
      din = (p == slot) ? rxw[1] : (p == slot + 1) ? rxw[0] : ~rxw[0];
      exp = (p == slot) ? txe[1] : (p == slot + 1) ? txe[0] : 1'b1;
      bclk_period(k == 0, din, ds, cs);
      if (ds !== exp) begin
        bad++;
        $display("FAIL R5 %s pos %0d: actual %0b expected %0b", tag, k, ds, exp);
      end
      if (cs) dclk_hi++;
    end
    repeat (3) @(negedge clk);
    tests++;
    if (bad != 0) fails++;
    chk({"R10 dclk quiet ", tag}, dclk_hi, 0);
    chk({"R8 ready pulses ", tag}, rdy_cnt, 1);
    chk({"R8 handshakes ", tag}, hs_cnt, txv ? 1 : 0);
    chk({"R9 rx strobes ", tag}, rx_cnt, 1);
    chk({"R6 rx word ", tag}, int'(rx_hist[0]), int'(rxw));
  endtask

  // R2 R3 R4: free-running mode
  task automatic free_run();
    logic [7:0] pat = 8'b1101_0010;
    logic pd, po;
    int j = 0, run_len = 0, bad_len = 0, bad_move = 0, bad_bit = 0, guard = 0;
    port_en = 0; mode_sel = 1; fmt4_sel = 0; tx_data = 2'b10; tx_valid = 1;
    repeat (2) @(negedge clk);
    clear_counts();
    port_en = 1;
    @(negedge clk);
    chk("R3 idle before first rise", d_out, 1);
    pd = dclk_out; po = d_out; run_len = 1;
    while (j < 8 && guard < 500) begin
      @(negedge clk);
      guard++;
      if (dclk_out != pd) begin
        if (j >= 1 && run_len != HP) bad_len++;
        run_len = 1;
      end else run_len++;
      if (dclk_out && !pd) begin
        if (d_out !== ((j % 2 == 0) ? tx_data[1] : tx_data[0])) bad_bit++;
        d_in = pat[7 - j];
        j++;
      end else if (d_out != po) bad_move++;
      pd = dclk_out; po = d_out;
    end
    repeat (2 * HP) @(negedge clk);
    chk("R2 half period", bad_len, 0);
    chk("R3 move only on rise", bad_move, 0);
    chk("R3 bit order out", bad_bit, 0);
    chk("R4 word 0", int'(rx_hist[0]), int'(pat[7:6]));
    chk("R4 word 1", int'(rx_hist[1]), int'(pat[5:4]));
    port_en = 0;
  endtask

  // R1: disabled port ignores bus activity
  task automatic disabled_port();
    int bad = 0, dhi = 0;
    logic ds, cs;
    port_en = 0; mode_sel = 0; slot_pos = '0; tx_valid = 1; tx_data = 2'b00;
    clear_counts();
    for (int k = 0; k < 6; k++) begin
      bclk_period(k == 0, 1'b0, ds, cs);
      if (ds !== 1'b1) bad++;
    end
    mode_sel = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (dclk_out) dhi++;
    end
    chk("R1 d_out high", bad, 0);
    chk("R1 dclk low", dhi, 0);
    chk("R1 no ready", rdy_cnt, 0);
    chk("R1 no rx", rx_cnt, 0);
    mode_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset d_out", d_out, 1);
    chk("R1 reset dclk", dclk_out, 0);
    chk("R9 reset rx_valid", rx_valid, 0);
    disabled_port();
    slot_frame(0, 1'b0, 2'b01, 1'b1, 2'b10, "slot0");
    slot_frame(5, 1'b0, 2'b10, 1'b1, 2'b01, "slot5");
    slot_frame(14, 1'b0, 2'b00, 1'b1, 2'b11, "slot14");
    slot_frame(3, 1'b1, 2'b01, 1'b1, 2'b10, "fmt4");
    slot_frame(2, 1'b0, 2'b00, 1'b0, 2'b01, "starved");
    port_en = 0;
    free_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule